// File: doc/BRIEF.md
# Multi-Thread Time-Aware Gate Scheduler

This block drives the per-traffic-class transmission gates of an egress scheduler from a single gate table that every port shares. The table holds up to `TBL_DEPTH` entries; each entry pairs an 8-bit gate mask (bit n open means traffic class n may transmit) with a 19-bit hold time counted in scheduler ticks, where one tick is 200 ns and arrives as a one-cycle `tick` strobe. Up to `NUM_THREADS` independent threads walk disjoint slices of that table. Each thread has its own start address, end index and activation offset, and it loops over its slice for as long as the scheduler runs.

Software loads the table, the thread parameters and a base time while the scheduler is stopped, then starts it by setting `enable` with a nonzero time-source code. A thread stays parked with all gates open until the selected time reaches base time plus its offset. From then on it cycles through its entries. The schedule is static: a new schedule is loaded by stopping the scheduler, writing, and restarting. The block does not check whether a frame fits its gate interval. It does, however, flag in a sticky bit the illegal case of two threads switching entries in the same clock cycle.

Top module: `gsched_top`

## Requirements
- R1: After a cycle with `rst` high, every thread reports gate mask 8'hFF, entry index 0 and inactive, `collision` is 0, and every thread is marked invalid.
- R2: While `enable` is low or `clk_src` is 0, every thread is idle with mask 8'hFF, index 0 and `thr_active` 0, and the free-running tick counter is held at 0.
- R3: A valid thread waits with gates open until the selected time is at least `base_time` plus its offset (32-bit wrapping sum). At the first clock edge where this holds, it loads its start entry. The entry's mask, the start index and `thr_active`=1 appear after that edge.
- R4: A running thread keeps an entry for as many `tick` strobes as the entry's hold value, then loads the next index at the edge of the last strobe. A hold value of 0 behaves like 1.
- R5: After holding the entry at its end index, a thread returns to its start address and repeats indefinitely. A thread whose start equals its end holds that one entry permanently.
- R6: `clk_src` 1 selects an internal counter that counts `tick` strobes from 0 from the moment the scheduler starts. `clk_src` 2 and 3 both compare against the `ext_time` input.
- R7: A thread marked invalid stays idle with mask 8'hFF and index 0 even while the scheduler runs.
- R8: Writes to the table, the thread parameters or the base time are ignored while the scheduler runs (enable high and `clk_src` nonzero). They are accepted while it is stopped and take effect at the next start.
- R9: When two or more threads load an entry in the same clock cycle, `collision` rises after that edge and stays high until `rst`, including while the scheduler is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scheduler run request |
| clk_src | input | 2 | Time source: 0 off, 1 internal tick counter, 2 and 3 external time |
| tick | input | 1 | One-cycle strobe per 200 ns scheduler unit |
| ext_time | input | TIME_W | External synchronized time in ticks |
| tbl_we | input | 1 | Gate table write strobe |
| tbl_addr | input | AW | Gate table write address |
| tbl_mask | input | 8 | Gate mask to write |
| tbl_delta | input | 19 | Hold time to write, in ticks |
| thr_we | input | 1 | Thread parameter write strobe |
| thr_sel | input | TW | Thread being written |
| thr_valid | input | 1 | Thread in use |
| thr_start | input | AW | Thread start address |
| thr_end | input | AW | Thread end index |
| thr_offset | input | TIME_W | Thread activation offset from base time |
| base_we | input | 1 | Base time write strobe |
| base_time | input | TIME_W | Base time value |
| gate_mask | output | NUM_THREADS*8 | Gate mask per thread, thread n in bits [8n+7:8n] |
| entry_idx | output | NUM_THREADS*AW | Current entry index per thread |
| thr_active | output | NUM_THREADS | Thread is running its slice |
| collision | output | 1 | Sticky flag: two threads loaded in one cycle |

## Verification
The bench runs threads whose slices include zero hold times, a single-entry slice and an invalid thread, under each time-source code. A design that counted a zero hold as an endless or doubled interval, or that wrapped to index 0 instead of the start address, would drift from the model at the first entry change. It also rewrites the schedule mid-run and restarts the scheduler, so a design that let writes through while running would show the altered mask on restart. Finally, it starts two identical threads to force a same-cycle load, and checks that the flag survives a stop and clears only on reset.

// File: rtl/gsched_pkg.sv
package gsched_pkg;

    localparam int unsigned TC_W    = 8;
    localparam int unsigned DELTA_W = 19;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_FREE   = 2'd1,
        SRC_SYNC_A = 2'd2,
        SRC_SYNC_B = 2'd3
    } time_src_e;

    typedef enum logic {
        TH_WAIT = 1'b0,
        TH_RUN  = 1'b1
    } thr_state_e;

    typedef struct packed {
        logic [TC_W-1:0]    mask;
        logic [DELTA_W-1:0] delta;
    } gate_entry_t;

    function automatic logic src_on(input time_src_e s);
        return s != SRC_OFF;
    endfunction

endpackage

// File: rtl/gsched_table.sv
module gsched_table
    import gsched_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned NRD   = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  gate_entry_t                wentry,
    input  logic [NRD-1:0][AW-1:0]     raddr,
    output gate_entry_t [NRD-1:0]      rentry
);

    gate_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wentry;
        end
    end

    // One asynchronous read port per thread.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rentry[g] = mem[raddr[g]];
    end

endmodule

// File: rtl/gsched_thread.sv
module gsched_thread
    import gsched_pkg::*;
#(
    parameter int unsigned AW     = 5,
    parameter int unsigned TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              valid,
    input  logic [AW-1:0]     start_addr,
    input  logic [AW-1:0]     end_addr,
    input  logic [TIME_W-1:0] start_time,
    input  logic [TIME_W-1:0] cur_time,
    output logic [AW-1:0]     rd_addr,
    input  gate_entry_t       rd_entry,
    output logic [TC_W-1:0]   gate,
    output logic [AW-1:0]     idx,
    output logic              active,
    output logic              load
);

    thr_state_e         state_q;
    logic [AW-1:0]      idx_q;
    logic [DELTA_W-1:0] rem_q;
    logic [TC_W-1:0]    gate_q;
    logic [AW-1:0]      nxt_idx;
    logic               time_hit;
    logic               last_tick;

    assign time_hit  = cur_time >= start_time;
    assign last_tick = tick && (rem_q <= DELTA_W'(1));
    assign nxt_idx   = (idx_q == end_addr) ? start_addr : idx_q + AW'(1);
    assign rd_addr   = (state_q == TH_RUN) ? nxt_idx : start_addr;

    always_comb begin
        load = 1'b0;
        if (run && valid) begin
            unique case (state_q)
                TH_WAIT: load = time_hit;
                TH_RUN:  load = last_tick;
                default: load = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || !valid) begin
            state_q <= TH_WAIT;
            idx_q   <= '0;
            rem_q   <= '0;
            gate_q  <= '1;
        end else if (load) begin
            state_q <= TH_RUN;
            idx_q   <= rd_addr;
            rem_q   <= rd_entry.delta;
            gate_q  <= rd_entry.mask;
        end else if (state_q == TH_RUN && tick) begin
            rem_q   <= rem_q - DELTA_W'(1);
        end
    end

    assign gate   = gate_q;
    assign idx    = idx_q;
    assign active = (state_q == TH_RUN);

endmodule

// File: rtl/gsched_collide.sv
module gsched_collide #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] load,
    output logic         flag
);

    localparam int unsigned CW = $clog2(N + 1);

    logic [CW-1:0] n_loads;
    logic          flag_q;

    always_comb begin
        n_loads = '0;
        for (int i = 0; i < N; i++) begin
            n_loads = n_loads + CW'(load[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (n_loads > CW'(1)) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/gsched_top.sv
module gsched_top
    import gsched_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 8,
    parameter int unsigned TBL_DEPTH   = 32,
    parameter int unsigned TIME_W      = 32,
    localparam int unsigned AW = $clog2(TBL_DEPTH),
    localparam int unsigned TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enable,
    input  logic [1:0]                  clk_src,
    input  logic                        tick,
    input  logic [TIME_W-1:0]           ext_time,
    input  logic                        tbl_we,
    input  logic [AW-1:0]               tbl_addr,
    input  logic [TC_W-1:0]             tbl_mask,
    input  logic [DELTA_W-1:0]          tbl_delta,
    input  logic                        thr_we,
    input  logic [TW-1:0]               thr_sel,
    input  logic                        thr_valid,
    input  logic [AW-1:0]               thr_start,
    input  logic [AW-1:0]               thr_end,
    input  logic [TIME_W-1:0]           thr_offset,
    input  logic                        base_we,
    input  logic [TIME_W-1:0]           base_time,
    output logic [NUM_THREADS*TC_W-1:0] gate_mask,
    output logic [NUM_THREADS*AW-1:0]   entry_idx,
    output logic [NUM_THREADS-1:0]      thr_active,
    output logic                        collision
);

    time_src_e src;
    logic      run;

    assign src = time_src_e'(clk_src);
    assign run = enable && src_on(src);

    // Configuration storage, writable only while stopped.
    logic [NUM_THREADS-1:0]              thr_valid_q;
    logic [NUM_THREADS-1:0][AW-1:0]      thr_start_q;
    logic [NUM_THREADS-1:0][AW-1:0]      thr_end_q;
    logic [NUM_THREADS-1:0][TIME_W-1:0]  thr_offs_q;
    logic [TIME_W-1:0]                   base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_valid_q <= '0;
            thr_start_q <= '0;
            thr_end_q   <= '0;
            thr_offs_q  <= '0;
            base_q      <= '0;
        end else if (!run) begin
            if (thr_we) begin
                thr_valid_q[thr_sel] <= thr_valid;
                thr_start_q[thr_sel] <= thr_start;
                thr_end_q[thr_sel]   <= thr_end;
                thr_offs_q[thr_sel]  <= thr_offset;
            end
            if (base_we) begin
                base_q <= base_time;
            end
        end
    end

    // Internal tick counter for the free-running source.
    logic [TIME_W-1:0] free_cnt_q;
    logic [TIME_W-1:0] cur_time;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            free_cnt_q <= '0;
        end else if (tick) begin
            free_cnt_q <= free_cnt_q + TIME_W'(1);
        end
    end

    assign cur_time = (src == SRC_FREE) ? free_cnt_q : ext_time;

    // Shared gate table.
    logic [NUM_THREADS-1:0][AW-1:0] rd_addr;
    gate_entry_t [NUM_THREADS-1:0]  rd_entry;
    gate_entry_t                    wr_entry;

    assign wr_entry = '{mask: tbl_mask, delta: tbl_delta};

    gsched_table #(
        .DEPTH (TBL_DEPTH),
        .NRD   (NUM_THREADS)
    ) u_table (
        .clk    (clk),
        .we     (tbl_we && !run),
        .waddr  (tbl_addr),
        .wentry (wr_entry),
        .raddr  (rd_addr),
        .rentry (rd_entry)
    );

    // Execution threads.
    logic [NUM_THREADS-1:0] thr_load;

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
        logic [TIME_W-1:0] start_time;
        assign start_time = base_q + thr_offs_q[g];

        gsched_thread #(
            .AW     (AW),
            .TIME_W (TIME_W)
        ) u_thread (
            .clk        (clk),
            .rst        (rst),
            .run        (run),
            .tick       (tick),
            .valid      (thr_valid_q[g]),
            .start_addr (thr_start_q[g]),
            .end_addr   (thr_end_q[g]),
            .start_time (start_time),
            .cur_time   (cur_time),
            .rd_addr    (rd_addr[g]),
            .rd_entry   (rd_entry[g]),
            .gate       (gate_mask[g*TC_W +: TC_W]),
            .idx        (entry_idx[g*AW +: AW]),
            .active     (thr_active[g]),
            .load       (thr_load[g])
        );
    end

    gsched_collide #(
        .N (NUM_THREADS)
    ) u_collide (
        .clk  (clk),
        .rst  (rst),
        .load (thr_load),
        .flag (collision)
    );

endmodule

// File: rtl/gsched_checker.sv
module gsched_checker #(
    parameter int unsigned NUM_THREADS = 8,
    parameter int unsigned AW          = 5
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       enable,
    input logic [1:0]                 clk_src,
    input logic                       tick,
    input logic [NUM_THREADS*8-1:0]   gate_mask,
    input logic [NUM_THREADS*AW-1:0]  entry_idx,
    input logic [NUM_THREADS-1:0]     thr_active,
    input logic                       collision,
    input logic [NUM_THREADS-1:0]     valid_q,
    input logic [NUM_THREADS-1:0]     loads
);

    // R1: state right after reset is all-open, idle, no collision.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gate_mask == '1 && thr_active == '0 && !collision));

    // R2: a stopped scheduler leaves every thread idle and open.
    a_r2_idle_open: assert property (@(posedge clk) disable iff (rst)
        (!enable || clk_src == 2'd0) |=> (gate_mask == '1 && thr_active == '0 && entry_idx == '0));

    // R9: collision is sticky.
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        collision |=> collision);

    // R9: simultaneous loads set the flag.
    a_r9_set: assert property (@(posedge clk) disable iff (rst)
        ($countones(loads) > 1) |=> collision);

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
        // R7: an invalid thread stays idle and open.
        a_r7_invalid_idle: assert property (@(posedge clk) disable iff (rst)
            !valid_q[g] |=> (gate_mask[g*8 +: 8] == 8'hFF && !thr_active[g]));

        // R4: no index change without a tick while running.
        a_r4_hold: assert property (@(posedge clk) disable iff (rst)
            (thr_active[g] && enable && clk_src != 2'd0 && !tick) |=> $stable(entry_idx[g*AW +: AW]));
    end

endmodule

bind gsched_top gsched_checker #(
    .NUM_THREADS (NUM_THREADS),
    .AW          (AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .clk_src    (clk_src),
    .tick       (tick),
    .gate_mask  (gate_mask),
    .entry_idx  (entry_idx),
    .thr_active (thr_active),
    .collision  (collision),
    .valid_q    (thr_valid_q),
    .loads      (thr_load)
);

// File: tb/tb_gsched_top.sv
module tb_gsched_top;

    localparam int NT = 8;
    localparam int DEPTH = 32;
    localparam int AW = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            enable = 1'b0;
    logic [1:0]      clk_src = 2'd0;
    logic            tick = 1'b0;
    logic [31:0]     ext_time = 32'd0;
    logic            tbl_we = 1'b0;
    logic [AW-1:0]   tbl_addr = '0;
    logic [7:0]      tbl_mask = '0;
    logic [18:0]     tbl_delta = '0;
    logic            thr_we = 1'b0;
    logic [2:0]      thr_sel = '0;
    logic            thr_valid = 1'b0;
    logic [AW-1:0]   thr_start = '0;
    logic [AW-1:0]   thr_end = '0;
    logic [31:0]     thr_offset = '0;
    logic            base_we = 1'b0;
    logic [31:0]     base_time = '0;
    logic [NT*8-1:0] gate_mask;
    logic [NT*AW-1:0] entry_idx;
    logic [NT-1:0]   thr_active;
    logic            collision;

    gsched_top dut (
        .clk(clk), .rst(rst), .enable(enable), .clk_src(clk_src), .tick(tick),
        .ext_time(ext_time), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_mask(tbl_mask),
        .tbl_delta(tbl_delta), .thr_we(thr_we), .thr_sel(thr_sel), .thr_valid(thr_valid),
        .thr_start(thr_start), .thr_end(thr_end), .thr_offset(thr_offset),
        .base_we(base_we), .base_time(base_time), .gate_mask(gate_mask),
        .entry_idx(entry_idx), .thr_active(thr_active), .collision(collision)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    model_on = 1'b0;
    string phase = "R1";

    // Stimulus helpers for free-running tick and external time.
    int tick_div = 3;
    bit tick_en = 1'b0;
    bit ext_en = 1'b0;

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c++;
            tick = tick_en && (c % tick_div == 0);
            if (ext_en && (c % 2 == 0)) ext_time = ext_time + 32'd1;
        end
    end

    // Reference model.
    logic [7:0]  t_mask [DEPTH];
    int          t_delta [DEPTH];
    bit          c_valid [NT];
    int          c_start [NT];
    int          c_end [NT];
    logic [31:0] c_off [NT];
    logic [31:0] c_base;
    int          m_state [NT];
    int          m_idx [NT];
    int          m_rem [NT];
    logic [7:0]  m_mask [NT];
    logic [31:0] m_free;
    bit          m_coll;

    always @(posedge clk) begin
        bit run;
        logic [31:0] tm;
        int loads;
        int k;
        run = enable && (clk_src != 2'd0);
        tm = (clk_src == 2'd1) ? m_free : ext_time;
        if (rst) begin
            model_on = 1'b1;
            for (int i = 0; i < NT; i++) begin
                m_state[i] = 0; m_idx[i] = 0; m_rem[i] = 0; m_mask[i] = 8'hFF;
                c_valid[i] = 1'b0; c_start[i] = 0; c_end[i] = 0; c_off[i] = 32'd0;
            end
            c_base = 32'd0;
            m_free = 32'd0;
            m_coll = 1'b0;
        end else if (model_on) begin
            loads = 0;
            for (int i = 0; i < NT; i++) begin
                if (!run || !c_valid[i]) begin
                    m_state[i] = 0; m_idx[i] = 0; m_rem[i] = 0; m_mask[i] = 8'hFF;
                end else if (m_state[i] == 0) begin
                    if (tm >= c_base + c_off[i]) begin
                        k = c_start[i];
                        m_state[i] = 1; m_idx[i] = k; m_mask[i] = t_mask[k]; m_rem[i] = t_delta[k];
                        loads++;
                    end
                end else if (tick) begin
                    if (m_rem[i] <= 1) begin
                        k = (m_idx[i] == c_end[i]) ? c_start[i] : (m_idx[i] + 1) % DEPTH;
                        m_idx[i] = k; m_mask[i] = t_mask[k]; m_rem[i] = t_delta[k];
                        loads++;
                    end else begin
                        m_rem[i]--;
                    end
                end
            end
            if (loads >= 2) m_coll = 1'b1;
            if (!run) m_free = 32'd0;
            else if (tick) m_free = m_free + 32'd1;
            if (!run) begin
                if (tbl_we) begin
                    t_mask[tbl_addr] = tbl_mask;
                    t_delta[tbl_addr] = int'(tbl_delta);
                end
                if (thr_we) begin
                    c_valid[thr_sel] = thr_valid; c_start[thr_sel] = int'(thr_start);
                    c_end[thr_sel] = int'(thr_end); c_off[thr_sel] = thr_offset;
                end
                if (base_we) c_base = base_time;
            end
        end
    end

    task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R3, R4, R5, R6, R7 by phase).
    always @(negedge clk) begin
        if (model_on && !rst && !done) begin
            logic [63:0] em;
            logic [63:0] ei;
            logic [7:0]  ea;
            em = '0; ei = '0; ea = '0;
            for (int i = 0; i < NT; i++) begin
                em[i*8 +: 8] = m_mask[i];
                ei[i*AW +: AW] = AW'(m_idx[i]);
                ea[i] = (m_state[i] == 1);
            end
            check(phase, "gate_mask", gate_mask, em);
            check(phase, "entry_idx", {24'd0, entry_idx}, ei);
            check(phase, "thr_active", {56'd0, thr_active}, {56'd0, ea});
            check(phase, "collision R9", {63'd0, collision}, {63'd0, m_coll});
        end
    end

    task automatic wr_entry(input int a, input logic [7:0] m, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = AW'(a); tbl_mask = m; tbl_delta = 19'(d);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wr_thread(input int t, input bit v, input int s, input int e, input int off);
        @(negedge clk);
        thr_we = 1'b1; thr_sel = 3'(t); thr_valid = v; thr_start = AW'(s); thr_end = AW'(e);
        thr_offset = 32'(off);
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic wr_base(input int b);
        @(negedge clk);
        base_we = 1'b1; base_time = 32'(b);
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports.
        check("R1", "mask after reset", gate_mask, {64{1'b1}});
        check("R1", "idx after reset", {24'd0, entry_idx}, 64'd0);
        check("R1", "active after reset", {56'd0, thr_active}, 64'd0);
        check("R1", "collision after reset", {63'd0, collision}, 64'd0);

        // Load the table; hold values include 0.
        for (int k = 0; k < DEPTH; k++) begin
            wr_entry(k, 8'((k * 37 + 5) % 256), k % 4);
        end
        wr_thread(0, 1'b1, 0, 3, 2);
        wr_thread(1, 1'b1, 4, 6, 5);
        wr_thread(2, 1'b1, 7, 7, 9);
        wr_thread(3, 1'b0, 10, 12, 0);
        wr_base(10);

        // R3 R4 R5 R6: free-running source.
        phase = "R3 R4 R5 R6 R7";
        tick_div = 3; tick_en = 1'b1;
        clk_src = 2'd1; enable = 1'b1;
        cycles(300);
        // R5: single-entry slice holds entry 7.
        check("R5", "thread2 mask", {56'd0, gate_mask[23:16]}, {56'd0, 8'((7 * 37 + 5) % 256)});
        check("R5", "thread2 idx", {59'd0, entry_idx[14:10]}, 64'd7);
        // R7: invalid thread 3 idle.
        check("R7", "thread3 mask", {56'd0, gate_mask[31:24]}, 64'hFF);

        // R8: writes while running are ignored.
        phase = "R8";
        wr_entry(1, 8'h00, 7);
        wr_thread(0, 1'b1, 0, 3, 40);
        wr_base(0);
        cycles(60);

        // R2: stop via enable, then via source 0.
        phase = "R2";
        enable = 1'b0;
        cycles(5);
        check("R2", "mask while disabled", gate_mask, {64{1'b1}});
        enable = 1'b1; clk_src = 2'd0;
        cycles(5);
        check("R2", "active with source off", {56'd0, thr_active}, 64'd0);
        clk_src = 2'd1;
        phase = "R8";
        cycles(120);

        // R6: external time, codes 2 and 3.
        enable = 1'b0;
        cycles(2);
        ext_time = 32'd0; ext_en = 1'b1; tick_div = 2;
        phase = "R6";
        clk_src = 2'd2; enable = 1'b1;
        cycles(150);
        enable = 1'b0;
        cycles(2);
        ext_time = 32'd0;
        clk_src = 2'd3; enable = 1'b1;
        cycles(150);

        // R9: two identical threads collide.
        enable = 1'b0; ext_en = 1'b0;
        cycles(2);
        phase = "R9";
        for (int t = 0; t < NT; t++) wr_thread(t, 1'b0, 0, 0, 0);
        wr_thread(4, 1'b1, 8, 9, 3);
        wr_thread(5, 1'b1, 8, 9, 3);
        wr_base(0);
        clk_src = 2'd1; enable = 1'b1;
        cycles(40);
        check("R9", "collision set", {63'd0, collision}, 64'd1);
        enable = 1'b0;
        cycles(10);
        check("R9", "collision sticky while stopped", {63'd0, collision}, 64'd1);
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "collision cleared by reset", {63'd0, collision}, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule